// File: doc/BRIEF.md
# Split Request/Response Bus Transducer

This block sits between a master and a slave that share one simple command/accept bus but disagree about writes. The master expects every write to be confirmed by a response, while the slave takes plain writes and never answers them; both sides agree on single reads. The transducer passes each master command to the slave and keeps a small queue recording what kind of answer is owed for every transaction the slave has taken. It passes slave read data straight back to the master and generates the write confirmations the slave never sends.

Requests and responses are handled by two independent state machines. The request machine has states REQ_IDLE, REQ_SEND and REQ_HOLD. Its transitions are: take (IDLE to SEND), take-behind-write (IDLE to HOLD, a read that arrives while a write confirmation is still owed), release (HOLD to SEND once no write is owed) and handoff (SEND to IDLE when the slave accepts, which also queues the kind tag). The response machine has states RSP_IDLE, RSP_RD_WAIT and RSP_WR_ACK. Its transitions are: read-at-head (IDLE to RD_WAIT), write-at-head (IDLE to WR_ACK), forward (RD_WAIT to IDLE, or a stay in IDLE, when slave read data arrives) and complete (WR_ACK to IDLE after a one-cycle confirmation). The only link between the two machines is the queue plus a count of owed write confirmations.

A slave is expected to answer a read in order, no earlier than the cycle after it accepts the read. Its answer lasts exactly one cycle and cannot be stalled.

Top module: `split_txn_bridge`

## Requirements
- R1: Reset, asserted low, empties the queue and sends both machines to idle: slave command is 000, master response is 00, and a slave response arriving after reset is not passed on.
- R2: Command codes are 3 bits: 000 idle, 001 write, 010 read. In REQ_IDLE, a 001 or 010 master command is accepted in the same cycle (command-accept high) when the queue has room. Any other code is never accepted and never reaches the slave.
- R3: From the cycle after acceptance, the captured command, address and write data are driven to the slave. They stay unchanged, regardless of the master inputs, until the slave asserts command-accept.
- R4: Master command-accept stays low from acceptance until the clock edge on which the slave accepts, so only one request is in flight at a time.
- R5: Response codes are 2 bits: 00 none, 01 data-valid. Suppose the slave accepts a write on edge k and nothing else is owed. Then the master sees response 01 with all-zero read data between edges k+1 and k+2, for that one cycle only.
- R6: When the oldest owed answer is a read and the slave drives response 01, the same cycle carries response 01 and the slave's read data to the master.
- R7: Answers reach the master in acceptance order. A read is not issued to the slave while any write confirmation is still owed, and the master is still accepted meanwhile.
- R8: The queue holds 4 two-bit kind tags. With 4 answers owed, master command-accept is withheld. It returns in the cycle after an answer frees an entry.
- R9: A slave response of 01 arriving while nothing is owed is ignored: the master response stays 00 and its read data stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_cmd | input | 3 | Master command code |
| m_addr | input | ADDR_W | Master address |
| m_wdata | input | DATA_W | Master write data |
| m_accept | output | 1 | Command accepted from master |
| m_resp | output | 2 | Response code to master |
| m_rdata | output | DATA_W | Read data to master |
| s_cmd | output | 3 | Command code to slave |
| s_addr | output | ADDR_W | Address to slave |
| s_wdata | output | DATA_W | Write data to slave |
| s_accept | input | 1 | Command accepted by slave |
| s_resp | input | 2 | Response code from slave |
| s_rdata | input | DATA_W | Read data from slave |

## Verification
The bench builds the block with its defaults: a queue of 4 entries and 16-bit address and data. With only four entries, a full queue is reached after four unanswered reads, so the withheld accept and its release on the first answer can be checked directly. Narrow data lets the bench swap in complemented master inputs during each slave stall to prove the captured values are held. The table-driven transactions vary the slave accept delay and the read answer delay. Directed cases then cover a read queued behind an owed write, back-to-back slave answers, stray slave answers and reset with an answer still owed.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam logic [2:0] CMD_IDLE  = 3'b000;
    localparam logic [2:0] CMD_WRITE = 3'b001;
    localparam logic [2:0] CMD_READ  = 3'b010;

    localparam logic [1:0] RSP_NONE  = 2'b00;
    localparam logic [1:0] RSP_DVA   = 2'b01;

    typedef enum logic [1:0] {
        TAG_NONE  = 2'b00,
        TAG_READ  = 2'b01,
        TAG_WRITE = 2'b10
    } tag_e;

    typedef enum logic [1:0] {
        REQ_IDLE = 2'd0,
        REQ_SEND = 2'd1,
        REQ_HOLD = 2'd2
    } req_state_e;

    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_RD_WAIT = 2'd1,
        RSP_WR_ACK  = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/stb_tag_fifo.sv
module stb_tag_fifo
    import stb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  tag_e push_tag,
    input  logic pop,
    output tag_e head,
    output logic empty,
    output logic full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    tag_e             slot [DEPTH];

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && (wr_ptr == PTR_W'(i))) begin
                    slot[i] <= push_tag;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = slot[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));

    // R8: the request side never queues into a full queue
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6: the response side never retires an entry that does not exist
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/stb_req_fsm.sv
module stb_req_fsm
    import stb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_accept,
    output logic [2:0]        s_cmd,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_accept,
    input  logic              fifo_full,
    input  logic              writes_owed,
    output logic              push,
    output tag_e              push_tag
);

    req_state_e        state;
    req_state_e        state_nxt;
    logic [2:0]        hold_cmd;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_wdata;
    logic              cmd_ok;

    assign cmd_ok = (m_cmd == CMD_WRITE) || (m_cmd == CMD_READ);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REQ_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_cmd   <= CMD_IDLE;
            hold_addr  <= '0;
            hold_wdata <= '0;
        end else if ((state == REQ_IDLE) && m_accept) begin
            hold_cmd   <= m_cmd;
            hold_addr  <= m_addr;
            hold_wdata <= m_wdata;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            REQ_IDLE: begin
                if (m_accept) begin
                    state_nxt = ((m_cmd == CMD_READ) && writes_owed) ? REQ_HOLD : REQ_SEND;
                end
            end
            REQ_HOLD: begin
                if (!writes_owed) begin
                    state_nxt = REQ_SEND;
                end
            end
            REQ_SEND: begin
                if (s_accept) begin
                    state_nxt = REQ_IDLE;
                end
            end
            default: state_nxt = REQ_IDLE;
        endcase
    end

    always_comb begin
        m_accept = 1'b0;
        s_cmd    = CMD_IDLE;
        push     = 1'b0;
        push_tag = TAG_NONE;
        unique case (state)
            REQ_IDLE: m_accept = cmd_ok && !fifo_full;
            REQ_HOLD: ;
            REQ_SEND: begin
                s_cmd = hold_cmd;
                if (s_accept) begin
                    push     = 1'b1;
                    push_tag = (hold_cmd == CMD_READ) ? TAG_READ : TAG_WRITE;
                end
            end
            default: ;
        endcase
    end

    assign s_addr  = hold_addr;
    assign s_wdata = hold_wdata;

    // R3: a stalled slave request keeps its command, address and data
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_cmd != CMD_IDLE) && !s_accept) |=>
            ((s_cmd == $past(s_cmd)) && $stable(s_addr) && $stable(s_wdata)));

    // R4: nothing new is taken from the master while a request is on the slave side
    p_single_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmd != CMD_IDLE) |-> !m_accept);

    // R7: a read only reaches the slave once no write completion is owed
    p_read_after_writes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmd == CMD_READ) |-> !writes_owed);

endmodule

// File: rtl/stb_rsp_fsm.sv
module stb_rsp_fsm
    import stb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty,
    input  tag_e              head,
    input  logic [1:0]        s_resp,
    input  logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        m_resp,
    output logic [DATA_W-1:0] m_rdata,
    output logic              pop
);

    rsp_state_e state;
    rsp_state_e state_nxt;
    logic       rd_here;

    assign rd_here = !fifo_empty && (head == TAG_READ) && (s_resp == RSP_DVA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RSP_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            RSP_IDLE: begin
                if (!rd_here && !fifo_empty) begin
                    state_nxt = (head == TAG_WRITE) ? RSP_WR_ACK : RSP_RD_WAIT;
                end
            end
            RSP_RD_WAIT: begin
                if (rd_here) begin
                    state_nxt = RSP_IDLE;
                end
            end
            RSP_WR_ACK: state_nxt = RSP_IDLE;
            default:    state_nxt = RSP_IDLE;
        endcase
    end

    always_comb begin
        m_resp  = RSP_NONE;
        m_rdata = '0;
        pop     = 1'b0;
        unique case (state)
            RSP_IDLE, RSP_RD_WAIT: begin
                if (rd_here) begin
                    m_resp  = RSP_DVA;
                    m_rdata = s_rdata;
                    pop     = 1'b1;
                end
            end
            RSP_WR_ACK: begin
                m_resp = RSP_DVA;
                pop    = 1'b1;
            end
            default: ;
        endcase
    end

    // R6: a slave answer for an owed transaction is passed on in the same cycle
    p_forward_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_resp == RSP_DVA) && !fifo_empty) |->
            ((m_resp == RSP_DVA) && (m_rdata == s_rdata)));

    // R9: a slave answer with nothing owed does not reach the master
    p_stray_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_resp == RSP_DVA) && fifo_empty) |-> (m_resp == RSP_NONE));

    // R5: a manufactured write completion carries zero data
    p_wr_ack_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_resp == RSP_DVA) && (s_resp != RSP_DVA)) |-> (m_rdata == '0));

endmodule

// File: rtl/split_txn_bridge.sv
module split_txn_bridge
    import stb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_accept,
    output logic [1:0]        m_resp,
    output logic [DATA_W-1:0] m_rdata,
    output logic [2:0]        s_cmd,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    input  logic              s_accept,
    input  logic [1:0]        s_resp,
    input  logic [DATA_W-1:0] s_rdata
);

    localparam int OWED_W = $clog2(DEPTH + 1);

    logic              push;
    tag_e              push_tag;
    logic              pop;
    tag_e              head;
    logic              fifo_empty;
    logic              fifo_full;
    logic [OWED_W-1:0] wr_owed;
    logic              wr_inc;
    logic              wr_dec;

    assign wr_inc = push && (push_tag == TAG_WRITE);
    assign wr_dec = pop && (head == TAG_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_owed <= '0;
        end else begin
            unique case ({wr_inc, wr_dec})
                2'b10:   wr_owed <= wr_owed + 1'b1;
                2'b01:   wr_owed <= wr_owed - 1'b1;
                default: wr_owed <= wr_owed;
            endcase
        end
    end

    stb_req_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .m_cmd       (m_cmd),
        .m_addr      (m_addr),
        .m_wdata     (m_wdata),
        .m_accept    (m_accept),
        .s_cmd       (s_cmd),
        .s_addr      (s_addr),
        .s_wdata     (s_wdata),
        .s_accept    (s_accept),
        .fifo_full   (fifo_full),
        .writes_owed (wr_owed != '0),
        .push        (push),
        .push_tag    (push_tag)
    );

    stb_tag_fifo #(
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_tag (push_tag),
        .pop      (pop),
        .head     (head),
        .empty    (fifo_empty),
        .full     (fifo_full)
    );

    stb_rsp_fsm #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .head       (head),
        .s_resp     (s_resp),
        .s_rdata    (s_rdata),
        .m_resp     (m_resp),
        .m_rdata    (m_rdata),
        .pop        (pop)
    );

    // R7: every answer to the master corresponds to an owed transaction
    p_resp_owed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_resp == RSP_DVA) |-> !fifo_empty);

    // R8: owed write completions never exceed the queue capacity
    p_owed_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_owed <= OWED_W'(DEPTH));

endmodule

// File: tb/test_split_txn_bridge.sv
module test_split_txn_bridge;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 16;
    localparam int DEPTH      = 4;
    localparam int NVEC       = 8;

    // {is_write, addr, wdata, slave rdata, accept delay, answer delay}
    localparam logic [52:0] VECS [NVEC] = '{
        {1'b1, 16'h1000, 16'hA5A5, 16'h0000, 2'd0, 2'd0},
        {1'b0, 16'h1004, 16'h0000, 16'h3C3C, 2'd0, 2'd0},
        {1'b1, 16'h2008, 16'h0F0F, 16'h0000, 2'd2, 2'd0},
        {1'b0, 16'h200C, 16'h0000, 16'hFFFF, 2'd1, 2'd3},
        {1'b0, 16'hFFFE, 16'h0000, 16'h8001, 2'd3, 2'd1},
        {1'b1, 16'h0000, 16'hFFFF, 16'h0000, 2'd1, 2'd0},
        {1'b1, 16'h7F7F, 16'h1234, 16'h0000, 2'd3, 2'd0},
        {1'b0, 16'h5555, 16'h0000, 16'h0001, 2'd2, 2'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        m_cmd = 3'b000;
    logic [ADDR_W-1:0] m_addr = '0;
    logic [DATA_W-1:0] m_wdata = '0;
    logic              m_accept;
    logic [1:0]        m_resp;
    logic [DATA_W-1:0] m_rdata;
    logic [2:0]        s_cmd;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;
    logic              s_accept = 1'b0;
    logic [1:0]        s_resp = 2'b00;
    logic [DATA_W-1:0] s_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    split_txn_bridge #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) i_split_txn_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_cmd    (m_cmd),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .m_accept (m_accept),
        .m_resp   (m_resp),
        .m_rdata  (m_rdata),
        .s_cmd    (s_cmd),
        .s_addr   (s_addr),
        .s_wdata  (s_wdata),
        .s_accept (s_accept),
        .s_resp   (s_resp),
        .s_rdata  (s_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_txn(input bit is_wr, input logic [15:0] addr,
                           input logic [15:0] wdata, input logic [15:0] rdata,
                           input int acc_d, input int rsp_d);
        logic [2:0] cmd;
        cmd = is_wr ? 3'b001 : 3'b010;
        m_cmd   = cmd;
        m_addr  = addr;
        m_wdata = wdata;
        #1;
        check("R2", "accept of valid command", 32'(m_accept), 32'd1);
        step();
        m_addr  = ~addr;
        m_wdata = ~wdata;
        for (int i = 0; i <= acc_d; i++) begin
            s_accept = (i == acc_d);
            #1;
            check("R3", "slave command", 32'(s_cmd), 32'(cmd));
            check("R3", "slave address held", 32'(s_addr), 32'(addr));
            if (is_wr) check("R3", "slave write data held", 32'(s_wdata), 32'(wdata));
            check("R4", "no accept while in flight", 32'(m_accept), 32'd0);
            step();
        end
        m_cmd    = 3'b000;
        s_accept = 1'b0;
        if (is_wr) begin
            #1;
            check("R5", "no completion before k+1", 32'(m_resp), 32'd0);
            step();
            #1;
            check("R5", "write completion code", 32'(m_resp), 32'd1);
            check("R5", "write completion data", 32'(m_rdata), 32'd0);
            step();
            #1;
            check("R5", "completion lasts one cycle", 32'(m_resp), 32'd0);
        end else begin
            for (int j = 0; j <= rsp_d; j++) begin
                s_resp  = (j == rsp_d) ? 2'b01 : 2'b00;
                s_rdata = (j == rsp_d) ? rdata : 16'hDEAD;
                #1;
                if (j < rsp_d) begin
                    check("R6", "no answer while slave silent", 32'(m_resp), 32'd0);
                end else begin
                    check("R6", "read answer code", 32'(m_resp), 32'd1);
                    check("R6", "read answer data", 32'(m_rdata), 32'(rdata));
                end
                step();
            end
            s_resp = 2'b00;
            #1;
            check("R6", "read answer lasts one cycle", 32'(m_resp), 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [52:0] e;
        bit wack;
        bit rd_sent;

        // R1: reset state
        repeat (3) step();
        #1;
        check("R1", "slave command in reset", 32'(s_cmd), 32'd0);
        check("R1", "master response in reset", 32'(m_resp), 32'd0);
        check("R1", "accept in reset", 32'(m_accept), 32'd0);
        step();
        rst_n = 1'b1;
        step();

        // table of transactions
        for (int v = 0; v < NVEC; v++) begin
            e = VECS[v];
            run_txn(e[52], e[51:36], e[35:20], e[19:4], int'(e[3:2]), int'(e[1:0]));
        end

        // R2: undefined command codes are not taken
        step();
        m_cmd = 3'b011;
        #1;
        check("R2", "code 011 not accepted", 32'(m_accept), 32'd0);
        step();
        m_cmd = 3'b100;
        #1;
        check("R2", "code 011 not forwarded", 32'(s_cmd), 32'd0);
        check("R2", "code 100 not accepted", 32'(m_accept), 32'd0);
        step();
        m_cmd = 3'b000;
        #1;
        check("R2", "code 100 not forwarded", 32'(s_cmd), 32'd0);
        step();

        // R7: read queued behind an owed write
        m_cmd   = 3'b001;
        m_addr  = 16'hAAAA;
        m_wdata = 16'h5A5A;
        #1;
        check("R7", "write accepted", 32'(m_accept), 32'd1);
        step();
        m_cmd    = 3'b000;
        s_accept = 1'b1;
        #1;
        check("R7", "write on slave", 32'(s_cmd), 32'd1);
        step();
        s_accept = 1'b0;
        m_cmd    = 3'b010;
        m_addr   = 16'hBBBB;
        #1;
        check("R7", "read accepted while write owed", 32'(m_accept), 32'd1);
        step();
        m_cmd   = 3'b000;
        wack    = 1'b0;
        rd_sent = 1'b0;
        for (int k = 0; k < 10 && !rd_sent; k++) begin
            #1;
            if (m_resp == 2'b01) begin
                wack = 1'b1;
                check("R7", "read held during write completion", 32'(s_cmd), 32'd0);
                check("R7", "write completion data", 32'(m_rdata), 32'd0);
            end
            if (s_cmd == 3'b010) begin
                check("R7", "read issued after write completion", 32'(wack), 32'd1);
                check("R7", "held read address", 32'(s_addr), 32'h0000BBBB);
                s_accept = 1'b1;
                rd_sent  = 1'b1;
            end
            step();
            s_accept = 1'b0;
        end
        check("R7", "held read eventually issued", 32'(rd_sent), 32'd1);
        s_resp  = 2'b01;
        s_rdata = 16'h7777;
        #1;
        check("R7", "read answer after write", 32'(m_resp), 32'd1);
        check("R7", "read answer data after write", 32'(m_rdata), 32'h00007777);
        step();
        s_resp = 2'b00;

        // R8: full queue withholds accept
        for (int i = 0; i < DEPTH; i++) begin
            m_cmd  = 3'b010;
            m_addr = 16'(i);
            #1;
            check("R8", "read accepted with room", 32'(m_accept), 32'd1);
            step();
            m_cmd    = 3'b000;
            s_accept = 1'b1;
            #1;
            step();
            s_accept = 1'b0;
        end
        m_cmd  = 3'b010;
        m_addr = 16'h0055;
        #1;
        check("R8", "accept withheld when full", 32'(m_accept), 32'd0);
        step();
        #1;
        check("R8", "still withheld when full", 32'(m_accept), 32'd0);
        check("R8", "nothing forwarded when full", 32'(s_cmd), 32'd0);
        s_resp  = 2'b01;
        s_rdata = 16'h0100;
        #1;
        check("R8", "answer passes while full", 32'(m_resp), 32'd1);
        check("R8", "answer data while full", 32'(m_rdata), 32'h00000100);
        check("R8", "withheld in freeing cycle", 32'(m_accept), 32'd0);
        step();
        s_resp = 2'b00;
        #1;
        check("R8", "accept returns after free", 32'(m_accept), 32'd1);
        step();
        m_cmd    = 3'b000;
        s_accept = 1'b1;
        #1;
        check("R8", "freed-slot read forwarded", 32'(s_addr), 32'h00000055);
        step();
        s_accept = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            s_resp  = 2'b01;
            s_rdata = 16'h0200 + 16'(i);
            #1;
            check("R6", "back-to-back answer code", 32'(m_resp), 32'd1);
            check("R6", "back-to-back answer data", 32'(m_rdata), 32'h00000200 + 32'(i));
            step();
        end
        s_resp = 2'b00;
        #1;
        check("R6", "queue drained", 32'(m_resp), 32'd0);
        step();

        // R9: stray slave answer
        s_resp  = 2'b01;
        s_rdata = 16'hBEEF;
        #1;
        check("R9", "stray answer code", 32'(m_resp), 32'd0);
        check("R9", "stray answer data", 32'(m_rdata), 32'd0);
        step();
        s_resp = 2'b00;

        // R1: reset with an answer owed
        m_cmd  = 3'b010;
        m_addr = 16'h0F00;
        #1;
        step();
        m_cmd    = 3'b000;
        s_accept = 1'b1;
        #1;
        step();
        s_accept = 1'b0;
        rst_n    = 1'b0;
        #1;
        check("R1", "slave command during reset", 32'(s_cmd), 32'd0);
        check("R1", "master response during reset", 32'(m_resp), 32'd0);
        step();
        step();
        rst_n   = 1'b1;
        s_resp  = 2'b01;
        s_rdata = 16'h4242;
        #1;
        check("R1", "owed answer dropped by reset", 32'(m_resp), 32'd0);
        step();
        s_resp = 2'b00;
        run_txn(1'b1, 16'h3030, 16'hC0DE, 16'h0000, 1, 0);

        step();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule